// File: doc/BRIEF.md
# Scrambled AMI Burst Line Coder

This block is the digital core of a burst-mode (ping-pong) transceiver for a twisted pair. On the send side it takes a parallel payload that holds two frames of channel data. It emits one ternary line symbol per symbol strobe: first an unscrambled start mark, then the payload bits, each passed through a self-synchronizing scrambler with polynomial x^9 + x^5 + 1 and coded with alternate mark inversion. The alternation of mark polarity carries on from one burst to the next, so the start mark always has the opposite polarity to the last mark of the previous burst.

On the receive side it takes sliced ternary symbols and waits for the first mark, which it treats as the start of a burst. It then collects and descrambles the next payload-width symbols and hands the payload over in parallel with a one-cycle pulse. A sticky flag records every breach of the alternation rule and every illegal symbol code until an external clear. Filtering, equalization, timing recovery and the line driver lie outside the block; the symbol strobe comes from the surrounding timing logic.

Top module: `ami_burst_codec`

## Requirements
- R1: A line symbol is two bits: 2'b01 is a positive mark, 2'b11 a negative mark, 2'b00 a zero. A 1 is sent as a mark whose polarity is opposite to the previous mark sent, and a 0 as a zero. tx_sym changes only on a sym_stb cycle, and it is 2'b00 after reset and on any strobe while no burst is in progress.
- R2: A burst starts with one start mark that is always a 1 and is not scrambled. Its polarity is opposite to the last mark of the previous burst, and the first mark after reset is positive.
- R3: After a tx_start pulse the next 37 strobes carry the start mark and then tx_payload bits 35 down to 0, most significant first. Bits [35:18] are frame 0 and [17:0] frame 1, each ordered B1 (8 bits), B2 (8 bits), D (2 bits). tx_busy is high from the cycle after tx_start until the 37th strobe.
- R4: Payload bit d is sent as s[n] = d[n] ^ s[n-5] ^ s[n-9], where s is the history of scrambled payload bits. The history is cleared by reset, kept across bursts, and not advanced by the start mark.
- R5: Received payload line bit r (1 for any mark) is descrambled as d[n] = r[n] ^ r[n-5] ^ r[n-9], using the history of received payload line bits. Reset clears this history.
- R6: While rx_en is high and no burst is being received, the first strobed mark starts a burst. The next 36 strobed symbols are the payload. After the last one, rx_done pulses for one cycle and rx_payload holds the bits in the bit order of R3.
- R7: viol_flag is set and held when a strobed received mark has the same polarity as the previous received mark, or when a strobed symbol is 2'b10. The comparison runs across the start/payload boundary and across bursts, and it is made against a negative mark after reset. A 2'b10 symbol counts as a 0 bit, does not start a burst, and does not update the last polarity. A new violation wins over a clear in the same cycle.
- R8: A viol_clr pulse with no violation in the same cycle leaves viol_flag low.
- R9: While rx_en is low, received symbols are ignored: no burst starts, no violation is flagged, and the last received polarity is not updated.
- R10: A tx_start while tx_busy is high is ignored, and the burst in progress completes with its original payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_stb | input | 1 | One-cycle strobe marking each line symbol period |
| tx_start | input | 1 | Pulse that starts a burst with tx_payload |
| tx_payload | input | 36 | Two frames of B1, B2 and D bits to send |
| tx_busy | output | 1 | A burst is being sent |
| tx_sym | output | 2 | Ternary transmit symbol |
| rx_en | input | 1 | Receiver enable (receive window) |
| rx_sym | input | 2 | Sliced ternary receive symbol |
| viol_clr | input | 1 | Clears the violation flag |
| rx_payload | output | 36 | Last received, descrambled payload |
| rx_done | output | 1 | One-cycle pulse when rx_payload is updated |
| viol_flag | output | 1 | Sticky coding-rule violation flag |

## Verification
The bench builds the block with its defaults: two frames of 8+8+2 bits and a scrambler of length 9 tapped at 5. That gives the real 36-bit burst, and the scrambler history wraps several times inside one burst. It loops the transmit symbols back into the receiver with a strobe every fourth cycle. It checks each transmitted symbol against a model of the coding and scrambling rules, and it checks each received payload against a model of the descrambler. Injected symbol streams then cover a start mark of repeated polarity, an illegal code, a repeated polarity across the start/payload boundary, clearing, and symbols sent while the receiver is disabled.

// File: rtl/ami_burst_pkg.sv
package ami_burst_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_POS  = 2'b01,
    SYM_BAD  = 2'b10,
    SYM_NEG  = 2'b11
  } ami_sym_e;

  function automatic ami_sym_e mark_of(input logic pos);
    return pos ? SYM_POS : SYM_NEG;
  endfunction

endpackage

// File: rtl/ami_scrambler.sv
module ami_scrambler #(
  parameter int LEN        = 9,
  parameter int TAP        = 5,
  parameter bit DESCRAMBLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic din,
  output logic dout
);

  logic [LEN-1:0] hist_q;
  logic [LEN-1:0] hist_d;
  logic           fb;
  logic           shift_in;

  assign fb   = hist_q[TAP-1] ^ hist_q[LEN-1];
  assign dout = din ^ fb;

  generate
    if (DESCRAMBLE) begin : g_line_hist
      assign shift_in = din;
    end else begin : g_out_hist
      assign shift_in = dout;
    end
  endgenerate

  always_comb begin
    hist_d = hist_q;
    if (step) hist_d = {hist_q[LEN-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // R4 / R5: the history only moves on a step
  p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(hist_q));

endmodule

// File: rtl/ami_tx_burst.sv
module ami_tx_burst
  import ami_burst_pkg::*;
#(
  parameter int PAYLOAD_W = 36,
  parameter int SCR_LEN   = 9,
  parameter int SCR_TAP   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sym_stb,
  input  logic                 start,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic                 busy,
  output logic [1:0]           sym
);

  localparam int CNT_W = $clog2(PAYLOAD_W + 1);

  logic                 busy_q, busy_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [PAYLOAD_W-1:0] sh_q, sh_d;
  logic                 last_pos_q, last_pos_d;
  ami_sym_e             sym_q, sym_d;
  logic                 emit, at_start, scr_step, scr_out, bit_out;

  assign emit     = sym_stb & busy_q;
  assign at_start = (cnt_q == '0);
  assign scr_step = emit & ~at_start;
  assign bit_out  = at_start ? 1'b1 : scr_out;

  ami_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP), .DESCRAMBLE(1'b0)) u_scr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (scr_step),
    .din  (sh_q[PAYLOAD_W-1]),
    .dout (scr_out)
  );

  always_comb begin
    busy_d     = busy_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    last_pos_d = last_pos_q;
    sym_d      = sym_q;
    if (emit) begin
      if (bit_out) begin
        sym_d      = mark_of(~last_pos_q);
        last_pos_d = ~last_pos_q;
      end else begin
        sym_d = SYM_ZERO;
      end
      if (!at_start) sh_d = sh_q << 1;
      if (cnt_q == CNT_W'(PAYLOAD_W)) busy_d = 1'b0;
      else                            cnt_d  = cnt_q + 1'b1;
    end else if (sym_stb) begin
      sym_d = SYM_ZERO;
    end
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      sh_d   = payload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      last_pos_q <= 1'b0;
      sym_q      <= SYM_ZERO;
    end else begin
      busy_q     <= busy_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      last_pos_q <= last_pos_d;
      sym_q      <= sym_d;
    end
  end

  assign busy = busy_q;
  assign sym  = sym_q;

  p_no_bad_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sym_q != SYM_BAD);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !busy_q) |=> sym_q == SYM_ZERO);
  p_start_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && at_start) |=> sym_q != SYM_ZERO);
  p_end_on_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(sym_stb));
  p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !sym_stb) |=> $stable(sh_q));

endmodule

// File: rtl/ami_rx_burst.sv
module ami_rx_burst
  import ami_burst_pkg::*;
#(
  parameter int PAYLOAD_W = 36,
  parameter int SCR_LEN   = 9,
  parameter int SCR_TAP   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sym_stb,
  input  logic                 en,
  input  logic [1:0]           sym,
  input  logic                 clr,
  output logic [PAYLOAD_W-1:0] payload,
  output logic                 done,
  output logic                 viol
);

  localparam int CNT_W = $clog2(PAYLOAD_W + 1);

  ami_sym_e             sym_e;
  logic                 collect_q, collect_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [PAYLOAD_W-1:0] sh_q, sh_d, out_q, out_d;
  logic                 last_pos_q, last_pos_d;
  logic                 done_q, done_d;
  logic                 viol_q, viol_d;
  logic                 take, is_pos, is_mark, is_bad, viol_ev, dscr_step, dscr_out;

  assign sym_e     = ami_sym_e'(sym);
  assign take      = sym_stb & en;
  assign is_pos    = (sym_e == SYM_POS);
  assign is_mark   = is_pos | (sym_e == SYM_NEG);
  assign is_bad    = (sym_e == SYM_BAD);
  assign viol_ev   = take & (is_bad | (is_mark & (is_pos == last_pos_q)));
  assign dscr_step = take & collect_q;

  ami_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP), .DESCRAMBLE(1'b1)) u_dscr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (dscr_step),
    .din  (is_mark),
    .dout (dscr_out)
  );

  always_comb begin
    collect_d  = collect_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    out_d      = out_q;
    last_pos_d = last_pos_q;
    done_d     = 1'b0;
    if (take && is_mark) last_pos_d = is_pos;
    if (take) begin
      if (!collect_q) begin
        if (is_mark) begin
          collect_d = 1'b1;
          cnt_d     = '0;
        end
      end else begin
        sh_d = {sh_q[PAYLOAD_W-2:0], dscr_out};
        if (cnt_q == CNT_W'(PAYLOAD_W - 1)) begin
          collect_d = 1'b0;
          out_d     = sh_d;
          done_d    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
    viol_d = viol_ev | (viol_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collect_q  <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      out_q      <= '0;
      last_pos_q <= 1'b0;
      done_q     <= 1'b0;
      viol_q     <= 1'b0;
    end else begin
      collect_q  <= collect_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      out_q      <= out_d;
      last_pos_q <= last_pos_d;
      done_q     <= done_d;
      viol_q     <= viol_d;
    end
  end

  assign payload = out_q;
  assign done    = done_q;
  assign viol    = viol_q;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_q && !clr) |=> viol_q);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !viol_ev) |=> !viol_q);
  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(collect_q) && $stable(last_pos_q) && !done_q));

endmodule

// File: rtl/ami_burst_codec.sv
module ami_burst_codec #(
  parameter int FRAMES  = 2,
  parameter int B_W     = 8,
  parameter int D_W     = 2,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sym_stb,
  input  logic                            tx_start,
  input  logic [FRAMES*(2*B_W+D_W)-1:0]   tx_payload,
  output logic                            tx_busy,
  output logic [1:0]                      tx_sym,
  input  logic                            rx_en,
  input  logic [1:0]                      rx_sym,
  input  logic                            viol_clr,
  output logic [FRAMES*(2*B_W+D_W)-1:0]   rx_payload,
  output logic                            rx_done,
  output logic                            viol_flag
);

  localparam int FRAME_W   = 2 * B_W + D_W;
  localparam int PAYLOAD_W = FRAMES * FRAME_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ami_tx_burst #(.PAYLOAD_W(PAYLOAD_W), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_tx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sym_stb(sym_stb),
    .start  (tx_start),
    .payload(tx_payload),
    .busy   (tx_busy),
    .sym    (tx_sym)
  );

  ami_rx_burst #(.PAYLOAD_W(PAYLOAD_W), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_rx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sym_stb(sym_stb),
    .en     (rx_en),
    .sym    (rx_sym),
    .clr    (viol_clr),
    .payload(rx_payload),
    .done   (rx_done),
    .viol   (viol_flag)
  );

endmodule

// File: tb/ami_burst_codec_bench.sv
module ami_burst_codec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STB_DIV    = 4;
  localparam int PW         = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sym_stb = 1'b0;
  logic          tx_start = 1'b0;
  logic [PW-1:0] tx_payload = '0;
  logic          tx_busy;
  logic [1:0]    tx_sym;
  logic          rx_en = 1'b0;
  logic [1:0]    rx_sym;
  logic          viol_clr = 1'b0;
  logic [PW-1:0] rx_payload;
  logic          rx_done;
  logic          viol_flag;
  logic          inj_on = 1'b0;
  logic [1:0]    inj_sym = 2'b00;

  int n_chk = 0;
  int n_fail = 0;
  int stb_cnt = 0;
  bit finished = 1'b0;

  logic [1:0]    sym_q[$];
  string         tag_q[$];
  logic [PW-1:0] pay_q[$];
  logic [8:0]    m_tx_h = '0;
  logic [8:0]    m_rx_h = '0;
  logic          m_tx_last = 1'b0;
  logic          m_rx_last = 1'b0;
  logic [1:0]    seq [0:PW];
  logic          chk_tx = 1'b0;

  assign rx_sym = inj_on ? inj_sym : tx_sym;

  ami_burst_codec u_ami_burst_codec (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .tx_start(tx_start),
    .tx_payload(tx_payload), .tx_busy(tx_busy), .tx_sym(tx_sym),
    .rx_en(rx_en), .rx_sym(rx_sym), .viol_clr(viol_clr),
    .rx_payload(rx_payload), .rx_done(rx_done), .viol_flag(viol_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      stb_cnt = 0;
      sym_stb = 1'b0;
    end else begin
      sym_stb = (stb_cnt == STB_DIV - 1);
      stb_cnt = (stb_cnt == STB_DIV - 1) ? 0 : stb_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) chk_tx <= tx_busy && sym_stb;

  always @(negedge clk) begin
    if (rst_n && chk_tx) begin
      if (sym_q.size() == 0) check(1'b0, "R10 unexpected tx symbol", {62'd0, tx_sym}, 64'd0);
      else begin
        logic [1:0] e;
        string t;
        e = sym_q.pop_front();
        t = tag_q.pop_front();
        check(tx_sym == e, t, {62'd0, tx_sym}, {62'd0, e});
      end
    end
    if (rst_n && rx_done) begin
      if (pay_q.size() == 0) check(1'b0, "R6 R9 unexpected rx_done", {28'd0, rx_payload}, 64'd0);
      else begin
        logic [PW-1:0] e;
        e = pay_q.pop_front();
        check(rx_payload == e, "R5 R6 rx payload", {28'd0, rx_payload}, {28'd0, e});
      end
    end
  end

  // expected symbols and looped-back payload for one burst
  task automatic push_burst(input logic [PW-1:0] p);
    logic [PW-1:0] exp;
    exp = '0;
    m_tx_last = ~m_tx_last;
    sym_q.push_back(m_tx_last ? 2'b01 : 2'b11);
    tag_q.push_back("R1 R2 start mark");
    m_rx_last = m_tx_last;
    for (int i = PW - 1; i >= 0; i--) begin
      logic s, r;
      s = p[i] ^ m_tx_h[4] ^ m_tx_h[8];
      m_tx_h = {m_tx_h[7:0], s};
      if (s) begin
        m_tx_last = ~m_tx_last;
        sym_q.push_back(m_tx_last ? 2'b01 : 2'b11);
        m_rx_last = m_tx_last;
      end else begin
        sym_q.push_back(2'b00);
      end
      tag_q.push_back("R1 R3 R4 payload symbol");
      r = s ^ m_rx_h[4] ^ m_rx_h[8];
      m_rx_h = {m_rx_h[7:0], s};
      exp = {exp[PW-2:0], r};
    end
    pay_q.push_back(exp);
  endtask

  task automatic send_burst(input logic [PW-1:0] p, input bit poke);
    @(negedge clk);
    push_burst(p);
    tx_payload = p;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    if (poke) begin
      // R10: second start mid-burst must be ignored
      repeat (10 * STB_DIV) @(negedge clk);
      tx_payload = ~p;
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
    end
    wait (tx_busy == 1'b0);
    repeat (3 * STB_DIV + 2) @(negedge clk);
    check(sym_q.size() == 0, "R3 R10 burst length", sym_q.size(), 0);
    check(tx_sym == 2'b00, "R1 idle line zero", {62'd0, tx_sym}, 0);
  endtask

  task automatic inj(input logic [1:0] s);
    @(posedge clk iff sym_stb);
    @(negedge clk);
    inj_sym = s;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
    check(viol_flag == 1'b0, "R8 flag cleared", viol_flag, 0);
  endtask

  task automatic inj_burst(input string tag);
    logic [PW-1:0] exp;
    logic ev;
    exp = '0;
    ev = 1'b0;
    for (int k = 0; k <= PW; k++) begin
      logic mk, r;
      mk = (seq[k] == 2'b01) || (seq[k] == 2'b11);
      if (seq[k] == 2'b10) ev = 1'b1;
      if (mk) begin
        if ((seq[k] == 2'b01) == m_rx_last) ev = 1'b1;
        m_rx_last = (seq[k] == 2'b01);
      end
      if (k > 0) begin
        r = mk ^ m_rx_h[4] ^ m_rx_h[8];
        m_rx_h = {m_rx_h[7:0], mk};
        exp = {exp[PW-2:0], r};
      end
    end
    pay_q.push_back(exp);
    pulse_clear();
    inj_sym = 2'b00;
    inj_on = 1'b1;
    for (int k = 0; k <= PW; k++) inj(seq[k]);
    inj(2'b00);
    inj(2'b00);
    @(negedge clk);
    check(viol_flag == ev, tag, viol_flag, ev);
    check(pay_q.size() == 0, "R6 burst delivered", pay_q.size(), 0);
  endtask

  function automatic logic [1:0] mk_sym(input logic pos);
    return pos ? 2'b01 : 2'b11;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(tx_sym == 2'b00, "R1 reset tx_sym", {62'd0, tx_sym}, 0);
    check(tx_busy == 1'b0, "R3 reset tx_busy", tx_busy, 0);
    check(rx_done == 1'b0, "R6 reset rx_done", rx_done, 0);
    check(viol_flag == 1'b0, "R7 reset viol_flag", viol_flag, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (6) @(negedge clk);

    send_burst(36'h0, 1'b0);
    send_burst(36'hFFFFFFFFF, 1'b0);
    send_burst(36'hA5C31E7B9, 1'b0);
    send_burst(36'h123456789, 1'b1);
    send_burst(36'hF00FF00C3, 1'b0);
    check(viol_flag == 1'b0, "R2 R7 no violation across looped bursts", viol_flag, 0);

    // R7: start mark repeating the previous burst's last polarity
    foreach (seq[k]) seq[k] = 2'b00;
    seq[0] = mk_sym(m_rx_last);
    inj_burst("R7 cross-burst start mark violation");

    // R7: illegal code inside payload
    foreach (seq[k]) seq[k] = 2'b00;
    seq[0] = mk_sym(~m_rx_last);
    seq[5] = 2'b10;
    seq[9] = mk_sym(m_rx_last);
    inj_burst("R7 illegal code violation");

    // R7: repeated polarity across start/payload boundary
    foreach (seq[k]) seq[k] = 2'b00;
    seq[0] = mk_sym(~m_rx_last);
    seq[1] = seq[0];
    inj_burst("R7 start-payload boundary violation");

    // R9: receiver disabled
    pulse_clear();
    rx_en = 1'b0;
    inj_on = 1'b1;
    inj(2'b01); inj(2'b01); inj(2'b11); inj(2'b10); inj(2'b11);
    repeat (40) inj(2'b00);
    @(negedge clk);
    check(viol_flag == 1'b0, "R9 no violation while disabled", viol_flag, 0);
    rx_en = 1'b1;

    // clean alternating burst after disable: hunt and last polarity untouched
    foreach (seq[k]) seq[k] = 2'b00;
    seq[0]  = mk_sym(~m_rx_last);
    seq[3]  = mk_sym(m_rx_last);
    seq[4]  = mk_sym(~m_rx_last);
    seq[20] = mk_sym(m_rx_last);
    seq[36] = mk_sym(~m_rx_last);
    inj_burst("R6 R9 clean injected burst");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R6 act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule